// File: doc/BRIEF.md
# Block Transfer Bus-Master Sequencer

This block moves a block of 16-bit words between a local word buffer and a parallel asynchronous bus once the bus has already been granted to it. A host fills or drains the buffer through its own port, then issues a start with a cycle code, an even start address and a word count. The sequencer then runs one fully interlocked bus cycle per word: it places address, cycle code and (for writes) data on the bus, waits a fixed setup time, raises master sync, waits for slave sync, drops master sync and waits for slave sync to fall before it moves on to the next even address.

A transfer ends in one of three ways: normal completion, a slave that never answers (timeout), or the bus INIT line being sensed. Each ending leaves a status code and an address for the host to read, and raises a one-cycle done pulse. Arbitration is outside this block, and so are byte cycles.

Top module: `dma_block_mover`

## Requirements
- R1: After synchronous reset, status is 0 (idle), master sync is low, the data drive enable is low and the done pulse is low.
- R2: The cycle code is 2 bits wide. 00 is a word read and 10 is a word write. A start with code 01 or 11, with a word count of 0, or with a count above MAX_WORDS (512) raises start_rejected for one cycle and starts no bus cycle. Status is left unchanged.
- R3: A write transfer of N words drives code 10 and the addresses S, S+2, ... S+2(N-1), where S is the start address with bit 0 cleared and the sum wraps modulo 2^AW. Word k carries buffer entry k, and the cycles run in this order.
- R4: A read transfer drives code 00 and stores the data returned in cycle k into buffer entry k, where the host port can read it back.
- R5: Address, code and write data are stable for at least SETUP_CYC clock cycles before master sync rises.
- R6: Master sync falls after slave sync is seen. The next master sync does not rise until slave sync has fallen.
- R7: If slave sync has not arrived within TIMEOUT_CYC cycles of master sync rising, master sync drops, status becomes 2 and the current address holds the address that failed.
- R8: On normal completion status returns to 0, the current address holds the last address accessed, and done is high for exactly one cycle, in the same cycle as the final status.
- R9: INIT sensed during a transfer ends it with master sync low, status 3 (stopped by INIT) and a done pulse.
- R10: A start that arrives while a transfer is running has no effect on that transfer.
- R11: A transfer of the full MAX_WORDS words runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| xfer_code | input | 2 | Bus cycle code: 00 read, 10 write |
| start_addr | input | AW | Byte start address; bit 0 is ignored |
| word_count | input | CW | Number of words, 1..MAX_WORDS |
| start_rejected | output | 1 | One-cycle pulse when a start is refused |
| host_we | input | 1 | Host buffer write enable |
| host_idx | input | IW | Host buffer index |
| host_wdata | input | DW | Host buffer write data |
| host_rdata | output | DW | Host buffer read data, one cycle after the index |
| bus_addr | output | AW | Bus address |
| bus_ctl | output | 2 | Bus cycle code |
| bus_dout | output | DW | Bus write data |
| bus_dout_en | output | 1 | Drive enable for bus write data |
| bus_msync | output | 1 | Master sync |
| bus_ssync | input | 1 | Slave sync response |
| bus_din | input | DW | Bus read data |
| bus_init | input | 1 | Bus INIT line |
| xfer_status | output | 2 | 0 idle, 1 running, 2 timeout, 3 stopped by INIT |
| cur_addr | output | AW | Current, last or failing address |
| xfer_done | output | 1 | One-cycle pulse when a transfer ends |

## Verification
Random read and write blocks vary the length, the start address (including odd addresses and a wrap past the top of the space) and the slave response delay. Varying the delay separates a sequencer that truly waits on the handshake from one that merely keeps time. Directed cases cover each illegal code and each out-of-range count, a hung slave in the middle of a block, INIT in the middle of a block, and a second start while busy. Together these show that each ending reports its own status and address, and that the order of the buffer entries is kept. A full 512-word write covers the upper count limit, and a slave-side monitor checks the setup window and the sync interlock on every cycle.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;
  // bus cycle codes as placed on the control lines; bit 1 marks a write
  localparam logic [1:0] CYC_RD_WORD  = 2'b00;
  localparam logic [1:0] CYC_RD_PAUSE = 2'b01;
  localparam logic [1:0] CYC_WR_WORD  = 2'b10;
  localparam logic [1:0] CYC_WR_BYTE  = 2'b11;

  typedef enum logic [1:0] {
    XS_IDLE    = 2'd0,
    XS_RUN     = 2'd1,
    XS_TIMEOUT = 2'd2,
    XS_INITSTP = 2'd3
  } xfer_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH,
    PH_SETUP,
    PH_WAIT,
    PH_RELEASE
  } phase_e;
endpackage

// File: rtl/dma_word_buffer.sv
module dma_word_buffer #(
  parameter int DEPTH = 512,
  parameter int DW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [IW-1:0] a_idx,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [IW-1:0] b_idx,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // one process for both ports; sequencer port wins an index clash
  always_ff @(posedge clk) begin
    if (a_we && !(b_we && (b_idx == a_idx))) mem[a_idx] <= a_wdata;
    if (b_we) mem[b_idx] <= b_wdata;
    a_rdata <= mem[a_idx];
    b_rdata <= mem[b_idx];
  end
endmodule

// File: rtl/dma_cycle_timer.sv
module dma_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (count != {W{1'b1}}) count <= count + 1'b1;
  end
endmodule

// File: rtl/dma_block_mover.sv
module dma_block_mover
  import dma_mover_pkg::*;
#(
  parameter int AW          = 18,
  parameter int DW          = 16,
  parameter int MAX_WORDS   = 512,
  parameter int SETUP_CYC   = 8,
  parameter int TIMEOUT_CYC = 64,
  localparam int CW = $clog2(MAX_WORDS + 1),
  localparam int IW = $clog2(MAX_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    xfer_code,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] word_count,
  output logic          start_rejected,
  input  logic          host_we,
  input  logic [IW-1:0] host_idx,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_ctl,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en,
  output logic          bus_msync,
  input  logic          bus_ssync,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_init,
  output logic [1:0]    xfer_status,
  output logic [AW-1:0] cur_addr,
  output logic          xfer_done
);
  localparam int TMAX = (SETUP_CYC > TIMEOUT_CYC) ? SETUP_CYC : TIMEOUT_CYC;
  localparam int TW   = $clog2(TMAX + 2);
  localparam logic [TW-1:0] SETUP_END = TW'(SETUP_CYC);
  localparam logic [TW-1:0] TMO_END   = TW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] CNT_MAX   = CW'(MAX_WORDS);

  phase_e        ph;
  xfer_status_e  status_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;
  logic [IW-1:0] idx_q;
  logic          is_wr_q;
  logic [TW-1:0] tcnt;
  logic          t_clear;
  logic [DW-1:0] b_rdata;
  logic          b_we;
  logic          code_ok, count_ok;

  assign code_ok  = (xfer_code == CYC_RD_WORD) || (xfer_code == CYC_WR_WORD);
  assign count_ok = (word_count != '0) && (word_count <= CNT_MAX);

  // timer restarts on entry to the setup window and to the sync wait
  assign t_clear = (ph == PH_FETCH) || ((ph == PH_SETUP) && (tcnt == SETUP_END));

  // a read cycle stores the slave's data in the buffer as slave sync is seen
  assign b_we = (ph == PH_WAIT) && bus_ssync && !is_wr_q && !bus_init;

  dma_cycle_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (t_clear),
    .count (tcnt)
  );

  dma_word_buffer #(.DEPTH(MAX_WORDS), .DW(DW)) u_buf (
    .clk     (clk),
    .a_we    (host_we),
    .a_idx   (host_idx),
    .a_wdata (host_wdata),
    .a_rdata (host_rdata),
    .b_we    (b_we),
    .b_idx   (idx_q),
    .b_wdata (bus_din),
    .b_rdata (b_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph             <= PH_IDLE;
      status_q       <= XS_IDLE;
      addr_q         <= '0;
      left_q         <= '0;
      idx_q          <= '0;
      is_wr_q        <= 1'b0;
      bus_ctl        <= CYC_RD_WORD;
      bus_dout       <= '0;
      bus_dout_en    <= 1'b0;
      bus_msync      <= 1'b0;
      xfer_done      <= 1'b0;
      start_rejected <= 1'b0;
    end else begin
      xfer_done      <= 1'b0;
      start_rejected <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            if (code_ok && count_ok) begin
              addr_q      <= {start_addr[AW-1:1], 1'b0};
              left_q      <= word_count;
              idx_q       <= '0;
              is_wr_q     <= xfer_code[1];
              bus_ctl     <= xfer_code;
              bus_dout_en <= xfer_code[1];
              status_q    <= XS_RUN;
              ph          <= PH_FETCH;
            end else begin
              start_rejected <= 1'b1;
            end
          end
        end
        PH_FETCH: ph <= PH_SETUP;
        PH_SETUP: begin
          if (is_wr_q) bus_dout <= b_rdata;
          if (tcnt == SETUP_END) begin
            bus_msync <= 1'b1;
            ph        <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (bus_ssync) begin
            bus_msync <= 1'b0;
            ph        <= PH_RELEASE;
          end else if (tcnt == TMO_END) begin
            bus_msync   <= 1'b0;
            bus_dout_en <= 1'b0;
            status_q    <= XS_TIMEOUT;
            xfer_done   <= 1'b1;
            ph          <= PH_IDLE;
          end
        end
        PH_RELEASE: begin
          if (!bus_ssync) begin
            if (left_q == CW'(1)) begin
              left_q      <= '0;
              bus_dout_en <= 1'b0;
              status_q    <= XS_IDLE;
              xfer_done   <= 1'b1;
              ph          <= PH_IDLE;
            end else begin
              left_q <= left_q - 1'b1;
              addr_q <= addr_q + AW'(2);
              idx_q  <= idx_q + 1'b1;
              ph     <= PH_FETCH;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
      // INIT overrides every running phase
      if ((ph != PH_IDLE) && bus_init) begin
        bus_msync   <= 1'b0;
        bus_dout_en <= 1'b0;
        status_q    <= XS_INITSTP;
        xfer_done   <= 1'b1;
        ph          <= PH_IDLE;
      end
    end
  end

  assign bus_addr    = addr_q;
  assign cur_addr    = addr_q;
  assign xfer_status = status_q;
endmodule

// File: rtl/dma_block_mover_chk.sv
module dma_block_mover_chk #(
  parameter int AW          = 18,
  parameter int DW          = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_ctl,
  input logic [DW-1:0] bus_dout,
  input logic          bus_msync,
  input logic          bus_ssync,
  input logic [1:0]    xfer_status,
  input logic          xfer_done
);
  localparam int CNTW = $clog2(TIMEOUT_CYC + 2);
  logic [CNTW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !bus_msync || bus_ssync) hi_cnt <= '0;
    else if (hi_cnt != {CNTW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    bus_msync |-> (xfer_status == 2'd1));

  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
    bus_msync |-> (bus_ctl[0] == 1'b0));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_msync && $past(bus_msync)) |-> ($stable(bus_addr) && $stable(bus_ctl)));

  p_setup_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_msync) |-> ($stable(bus_addr) && $stable(bus_dout)));

  p_interlock_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_msync) |-> !$past(bus_ssync));

  p_timeout_bound_r7: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= CNTW'(TIMEOUT_CYC));

  p_done_final_r8: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (xfer_status != 2'd1) && !bus_msync);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);
endmodule

bind dma_block_mover dma_block_mover_chk #(
  .AW(AW), .DW(DW), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_ctl     (bus_ctl),
  .bus_dout    (bus_dout),
  .bus_msync   (bus_msync),
  .bus_ssync   (bus_ssync),
  .xfer_status (xfer_status),
  .xfer_done   (xfer_done)
);

// File: tb/dma_block_mover_bench.sv
module dma_block_mover_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18, DW = 16, MAXW = 512, SETUP = 8, TMO = 64;
  localparam int CW = 10, IW = 9;

  logic clk = 0, rst = 1;
  logic start = 0;
  logic [1:0] xfer_code = 0;
  logic [AW-1:0] start_addr = 0;
  logic [CW-1:0] word_count = 0;
  logic start_rejected;
  logic host_we = 0;
  logic [IW-1:0] host_idx = 0;
  logic [DW-1:0] host_wdata = 0, host_rdata;
  logic [AW-1:0] bus_addr, cur_addr;
  logic [1:0] bus_ctl, xfer_status;
  logic [DW-1:0] bus_dout, bus_din;
  logic bus_dout_en, bus_msync, xfer_done;
  logic bus_ssync = 0, bus_init = 0;

  int checks = 0, fails = 0;

  dma_block_mover #(.AW(AW), .DW(DW), .MAX_WORDS(MAXW), .SETUP_CYC(SETUP),
                    .TIMEOUT_CYC(TMO)) u_dma_block_mover (
    .clk(clk), .rst(rst), .start(start), .xfer_code(xfer_code),
    .start_addr(start_addr), .word_count(word_count),
    .start_rejected(start_rejected), .host_we(host_we), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_addr(bus_addr),
    .bus_ctl(bus_ctl), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_msync(bus_msync), .bus_ssync(bus_ssync), .bus_din(bus_din),
    .bus_init(bus_init), .xfer_status(xfer_status), .cur_addr(cur_addr),
    .xfer_done(xfer_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- slave model ----------------
  int resp_dly = 0, wait_n = 0;
  bit hang_en = 0;
  logic [AW-1:0] hang_addr = 0;
  logic [AW-1:0] log_addr [MAXW];
  logic [DW-1:0] log_data [MAXW];
  logic [1:0]    log_ctl  [MAXW];
  int log_n = 0;
  int stab = 0, setup_bad = 0, hs_bad = 0;
  logic [AW-1:0] prv_addr = 0;
  logic [DW-1:0] prv_dout = 0;
  logic prv_msync = 0;

  function automatic logic [DW-1:0] rd_pat(logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[17:16], 14'd0};
  endfunction

  initial bus_din = 0;

  always @(negedge clk) begin
    if (bus_msync && !prv_msync) begin
      if (stab < SETUP) setup_bad++;
      if (bus_ssync) hs_bad++;
    end
    if (!bus_msync) begin
      if (bus_addr == prv_addr && bus_dout == prv_dout) stab++;
      else stab = 1;
    end
    prv_addr = bus_addr; prv_dout = bus_dout; prv_msync = bus_msync;
    if (bus_msync && !bus_ssync && !(hang_en && bus_addr == hang_addr)) begin
      if (wait_n >= resp_dly) begin
        if (log_n < MAXW) begin
          log_addr[log_n] = bus_addr;
          log_data[log_n] = bus_dout;
          log_ctl[log_n]  = bus_ctl;
        end
        log_n++;
        bus_din = rd_pat(bus_addr);
        bus_ssync = 1;
        wait_n = 0;
      end else wait_n++;
    end else if (!bus_msync && bus_ssync) begin
      bus_ssync = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [1:0] code, input logic [AW-1:0] a,
                             input logic [CW-1:0] n, output bit rej);
    @(negedge clk);
    xfer_code = code; start_addr = a; word_count = n; start = 1;
    @(negedge clk);
    rej = start_rejected;
    start = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (xfer_done) begin ok = 1; break; end
    end
  endtask

  logic [DW-1:0] exp_buf [MAXW];

  task automatic fill_buf(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      exp_buf[k] = DW'($urandom);
      host_we = 1; host_idx = IW'(k); host_wdata = exp_buf[k];
    end
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic run_block(input bit wr, input logic [AW-1:0] a, input int n,
                           input string tag);
    bit rej, ok, bad;
    logic [AW-1:0] s;
    s = {a[AW-1:1], 1'b0};
    if (wr) fill_buf(n);
    log_n = 0;
    pulse_start(wr ? 2'b10 : 2'b00, a, CW'(n), rej);
    chk({tag, " accepted"}, {31'd0, rej}, 0);
    wait_done(ok);
    chk({tag, " done R8"}, {31'd0, ok}, 1);
    chk({tag, " status R8"}, {30'd0, xfer_status}, 0);
    chk({tag, " last addr R8"}, {14'd0, cur_addr}, {14'd0, AW'(s + AW'(2*(n-1)))});
    chk({tag, " word count"}, log_n, n);
    bad = 0;
    for (int k = 0; k < n && k < MAXW; k++) begin
      if (log_addr[k] !== AW'(s + AW'(2*k))) bad = 1;
      if (log_ctl[k] !== (wr ? 2'b10 : 2'b00)) bad = 1;
      if (wr && log_data[k] !== exp_buf[k]) bad = 1;
    end
    chk(wr ? {tag, " R3 write order"} : {tag, " R4 read addr"}, {31'd0, bad}, 0);
    if (!wr) begin
      bad = 0;
      for (int k = 0; k < n; k++) begin
        @(negedge clk); host_idx = IW'(k);
        @(negedge clk);
        if (host_rdata !== rd_pat(AW'(s + AW'(2*k)))) bad = 1;
      end
      chk({tag, " R4 buffer data"}, {31'd0, bad}, 0);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", checks + 1, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    bit rej, ok, bad;
    logic [1:0] st0;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", {30'd0, xfer_status}, 0);
    chk("R1 msync", {31'd0, bus_msync}, 0);
    chk("R1 dout_en", {31'd0, bus_dout_en}, 0);
    chk("R1 done", {31'd0, xfer_done}, 0);

    // R3/R4 directed, odd start address and wrap
    resp_dly = 1;
    run_block(1, 18'h01235, 5, "R3 odd start");
    run_block(0, 18'h3FFFC, 4, "R4 wrap");

    // random blocks with varying response delay
    for (int t = 0; t < 8; t++) begin
      resp_dly = $urandom_range(0, 4);
      run_block($urandom_range(0, 1) == 1, AW'($urandom), $urandom_range(1, 24), "rand");
    end

    // R2 rejected starts
    st0 = xfer_status;
    pulse_start(2'b01, 18'h100, 10'd4, rej);
    chk("R2 code 01 rejected", {31'd0, rej}, 1);
    pulse_start(2'b11, 18'h100, 10'd4, rej);
    chk("R2 code 11 rejected", {31'd0, rej}, 1);
    pulse_start(2'b10, 18'h100, 10'd0, rej);
    chk("R2 count 0 rejected", {31'd0, rej}, 1);
    pulse_start(2'b00, 18'h100, 10'd513, rej);
    chk("R2 count 513 rejected", {31'd0, rej}, 1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bus_msync || xfer_status != st0) bad = 1;
    end
    chk("R2 no cycle after reject", {31'd0, bad}, 0);

    // R7 timeout in mid block
    resp_dly = 0; hang_en = 1; hang_addr = 18'h00206;
    fill_buf(6); log_n = 0;
    pulse_start(2'b10, 18'h00200, 10'd6, rej);
    wait_done(ok);
    chk("R7 done", {31'd0, ok}, 1);
    chk("R7 status", {30'd0, xfer_status}, 2);
    chk("R7 failing addr", {14'd0, cur_addr}, 32'h206);
    chk("R7 msync low", {31'd0, bus_msync}, 0);
    chk("R7 words before", log_n, 3);
    hang_en = 0;

    // R9 INIT in mid block
    resp_dly = 3; log_n = 0;
    fill_buf(10);
    pulse_start(2'b10, 18'h00400, 10'd10, rej);
    for (int i = 0; i < 5000 && log_n < 4; i++) @(negedge clk);
    bus_init = 1;
    wait_done(ok);
    bus_init = 0;
    chk("R9 done", {31'd0, ok}, 1);
    chk("R9 status", {30'd0, xfer_status}, 3);
    chk("R9 msync low", {31'd0, bus_msync}, 0);
    repeat (4) @(negedge clk);
    chk("R9 no further cycle", {31'd0, bus_msync}, 0);

    // R10 start while running is ignored
    resp_dly = 3; log_n = 0;
    fill_buf(5);
    pulse_start(2'b10, 18'h00800, 10'd5, rej);
    repeat (6) @(negedge clk);
    pulse_start(2'b00, 18'h01000, 10'd2, rej);
    wait_done(ok);
    bad = 0;
    for (int k = 0; k < 5; k++)
      if (log_addr[k] !== AW'(18'h00800 + 2*k) || log_ctl[k] !== 2'b10) bad = 1;
    chk("R10 busy start ignored", {31'd0, bad}, 0);
    chk("R10 word count", log_n, 5);
    chk("R10 last addr", {14'd0, cur_addr}, 32'h808);
    repeat (10) @(negedge clk);
    chk("R10 no second block", log_n, 5);

    // R11 full block
    resp_dly = 0;
    run_block(1, 18'h10000, MAXW, "R11 full");

    chk("R5 setup window", setup_bad, 0);
    chk("R6 sync interlock", hs_bad, 0);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule